// File: doc/BRIEF.md
# Programmable AND-OR Logic Macrocell

This block models one output cell of a small fuse-programmed logic device. A configuration word selects which literals enter each of eight product terms. A literal is one of the data inputs or the cell's own fed-back state, taken in true or complemented form. The eight terms are ORed together. A polarity bit can invert the result. A mode bit then chooses whether the cell drives that value straight through or through a D flip-flop clocked by the system clock. The cell value goes to a pin value output, and a separate enable output tells the pad whether to drive it.

The configuration sits in a register inside the cell. It is loaded on a clock edge while `cfg_load_i` is high, and it is meant to be written only while the cell's outputs are not in use. Every control and data pin is a plain level signal. No stream handshake exists and no back-pressure applies: the cell evaluates its inputs on every cycle, and its outputs are valid on every cycle.

The literal that is fed back into the array always comes from the flip-flop, which samples the polarity-stage value on every clock. In combinational mode this breaks what would otherwise be a zero-delay loop through the array. The `fb_o` port shows the mode-selected cell value.

Top module: `pal_macrocell`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears the configuration and the flip-flop to 0. With that all-zero configuration every term is empty, so after reset `pin_o` and `fb_o` are 1.
- R2: Term k takes configuration bits [k*2L +: 2L], where L = N_IN+1. Within a term, bit 2j enables literal j in true form and bit 2j+1 enables it in complemented form. Literals 0..N_IN-1 are `in_i` bits 0..N_IN-1, and literal N_IN is the fed-back flip-flop value. A term is the AND of its enabled literals.
- R3: A term with no enabled literal is 1. A term that enables both forms of the same literal is 0.
- R4: The OR stage is the OR of all N_PT (8) terms.
- R5: Configuration bit N_PT*2L (bit 80 by default) is the polarity bit. The polarity-stage value is the OR result XOR that bit.
- R6: Configuration bit N_PT*2L+1 (bit 81 by default) set to 1 selects registered mode. In that mode `pin_o` is the flip-flop, and the flip-flop takes the polarity-stage value at every clock edge.
- R7: With the mode bit at 0, `pin_o` equals the polarity-stage value in the same cycle.
- R8: The array's feedback literal is the flip-flop output in both modes, so in combinational mode it lags `pin_o` by one clock. `fb_o` equals `pin_o`: the flip-flop in registered mode, and the polarity-stage value in combinational mode.
- R9: `pin_en_o` follows `oe_i`, and `oe_i` has no effect on `pin_o` or `fb_o`.
- R10: The configuration register takes `cfg_word_i` at a clock edge where `cfg_load_i` is 1. When `cfg_load_i` is 0, `cfg_word_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_i | input | N_IN | Data inputs to the array |
| oe_i | input | 1 | Pin drive enable request |
| cfg_load_i | input | 1 | Load strobe for the configuration register |
| cfg_word_i | input | N_PT*2*(N_IN+1)+2 | Fuse map, polarity bit and mode bit |
| pin_o | output | 1 | Cell value presented to the pad |
| pin_en_o | output | 1 | Pad drive enable |
| fb_o | output | 1 | Mode-selected cell value for the rest of the device |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any check matters, and that all inputs are synchronous to `clk` and settled at each rising edge. They do not assume that a load happens only while the cell is idle. The bench changes every input one time unit after a rising edge, so the values are stable at the next edge. It loads the configuration with single-cycle strobes, and it drives noise on `cfg_word_i` while the strobe is low to show that this noise is ignored. The bench also exercises a reset in mid-run, the fed-back toggle loops in both modes, and random toggling of `oe_i`.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic {
    MODE_COMB = 1'b0,
    MODE_REG  = 1'b1
  } out_mode_e;

  function automatic int cfg_width(int n_in, int n_pt);
    return n_pt * 2 * (n_in + 1) + 2;
  endfunction
endpackage

// File: rtl/pal_product_term.sv
module pal_product_term #(
  parameter int N_LIT = 5
) (
  input  logic [N_LIT-1:0]   lit_i,
  input  logic [2*N_LIT-1:0] fuse_i,
  output logic               term_o
);
  always_comb begin
    term_o = 1'b1;
    for (int j = 0; j < N_LIT; j++) begin
      if (fuse_i[2*j] && !lit_i[j])
        term_o = 1'b0;
      if (fuse_i[2*j+1] && lit_i[j])
        term_o = 1'b0;
    end
  end
endmodule

// File: rtl/pal_and_or.sv
module pal_and_or #(
  parameter int N_LIT = 5,
  parameter int N_PT  = 8
) (
  input  logic [N_LIT-1:0]        lit_i,
  input  logic [N_PT*2*N_LIT-1:0] fuses_i,
  output logic [N_PT-1:0]         terms_o,
  output logic                    or_o
);
  localparam int TERM_W = 2 * N_LIT;

  for (genvar k = 0; k < N_PT; k++) begin : g_term
    pal_product_term #(.N_LIT(N_LIT)) u_term (
      .lit_i  (lit_i),
      .fuse_i (fuses_i[k*TERM_W +: TERM_W]),
      .term_o (terms_o[k])
    );
  end

  assign or_o = |terms_o;
endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage
  import pal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      or_i,
  input  logic      pol_i,
  input  out_mode_e mode_i,
  output logic      pol_o,
  output logic      q_o,
  output logic      cell_o
);
  assign pol_o = or_i ^ pol_i;

  always_ff @(posedge clk) begin
    if (!rst_n)
      q_o <= 1'b0;
    else
      q_o <= pol_o;
  end

  assign cell_o = (mode_i == MODE_REG) ? q_o : pol_o;
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int N_PT = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_IN-1:0]              in_i,
  input  logic                         oe_i,
  input  logic                         cfg_load_i,
  input  logic [N_PT*2*(N_IN+1)+1:0]   cfg_word_i,
  output logic                         pin_o,
  output logic                         pin_en_o,
  output logic                         fb_o
);
  localparam int N_LIT    = N_IN + 1;
  localparam int ARR_W    = N_PT * 2 * N_LIT;
  localparam int POL_BIT  = ARR_W;
  localparam int MODE_BIT = ARR_W + 1;
  localparam int CFG_W    = cfg_width(N_IN, N_PT);

  logic [CFG_W-1:0] cfg_q;
  logic [N_LIT-1:0] lits;
  logic [N_PT-1:0]  term_vec;
  logic             or_val;
  logic             pol_val;
  logic             q_val;
  logic             cell_val;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (cfg_load_i)
      cfg_q <= cfg_word_i;
  end

  assign lits = {q_val, in_i};

  pal_and_or #(.N_LIT(N_LIT), .N_PT(N_PT)) u_array (
    .lit_i   (lits),
    .fuses_i (cfg_q[ARR_W-1:0]),
    .terms_o (term_vec),
    .or_o    (or_val)
  );

  pal_out_stage u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .or_i   (or_val),
    .pol_i  (cfg_q[POL_BIT]),
    .mode_i (out_mode_e'(cfg_q[MODE_BIT])),
    .pol_o  (pol_val),
    .q_o    (q_val),
    .cell_o (cell_val)
  );

  assign pin_o    = cell_val;
  assign fb_o     = cell_val;
  assign pin_en_o = oe_i;
endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk #(
  parameter int N_IN = 4,
  parameter int N_PT = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_load_i,
  input logic [N_PT*2*(N_IN+1)+1:0] cfg_word_i,
  input logic [N_PT*2*(N_IN+1)+1:0] cfg_q,
  input logic [N_PT-1:0]            term_vec,
  input logic                       or_val,
  input logic                       pol_val,
  input logic                       pin_o
);
  localparam int TERM_W   = 2 * (N_IN + 1);
  localparam int POL_BIT  = N_PT * TERM_W;
  localparam int MODE_BIT = POL_BIT + 1;

  // R10: a load strobe captures the word
  p_cfg_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_i |=> cfg_q == $past(cfg_word_i));

  // R10: without a strobe the configuration holds
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load_i |=> $stable(cfg_q));

  // R3: empty term is true
  p_empty_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[TERM_W-1:0] == '0) |-> term_vec[0]);

  // R3: a literal with both forms enabled kills the term
  p_clash_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'b11) |-> !term_vec[0]);

  // R7: combinational mode passes the polarity-stage value
  p_comb_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[MODE_BIT] |-> pin_o == (or_val ^ cfg_q[POL_BIT]));

  // R6: registered mode shows the value sampled one edge earlier
  p_reg_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[MODE_BIT] && $past(cfg_q[MODE_BIT]) && $past(rst_n)) |->
      pin_o == $past(pol_val));
endmodule

bind pal_macrocell pal_macrocell_chk #(.N_IN(N_IN), .N_PT(N_PT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load_i (cfg_load_i),
  .cfg_word_i (cfg_word_i),
  .cfg_q      (cfg_q),
  .term_vec   (term_vec),
  .or_val     (or_val),
  .pol_val    (pol_val),
  .pin_o      (pin_o)
);

// File: tb/tb_pal_macrocell.sv
module tb_pal_macrocell;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN  = 4;
  localparam int N_PT  = 8;
  localparam int L     = N_IN + 1;
  localparam int TW    = 2 * L;
  localparam int CFG_W = N_PT * TW + 2;
  localparam int POLB  = N_PT * TW;
  localparam int MODEB = POLB + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [N_IN-1:0]  din;
  logic             oe;
  logic             cfg_load;
  logic [CFG_W-1:0] cfg_word;
  logic pin, pin_en, fb;

  pal_macrocell #(.N_IN(N_IN), .N_PT(N_PT)) dut (
    .clk(clk), .rst_n(rst_n), .in_i(din), .oe_i(oe),
    .cfg_load_i(cfg_load), .cfg_word_i(cfg_word),
    .pin_o(pin), .pin_en_o(pin_en), .fb_o(fb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit chk_on = 0;
  bit done   = 0;
  string tag = "R1";

  logic [CFG_W-1:0] cw;
  logic [CFG_W-1:0] m_cfg;
  logic             m_q;

  function automatic logic model_pol(logic [CFG_W-1:0] c, logic [N_IN-1:0] x, logic q);
    logic acc = 1'b0;
    for (int k = 0; k < N_PT; k++) begin
      logic t = 1'b1;
      for (int j = 0; j < L; j++) begin
        logic v = (j < N_IN) ? x[j] : q;
        if (c[k*TW + 2*j] && !v) t = 1'b0;
        if (c[k*TW + 2*j + 1] && v) t = 1'b0;
      end
      acc = acc | t;
    end
    return acc ^ c[POLB];
  endfunction

  // reference model state update
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg <= '0;
      m_q   <= 1'b0;
    end else begin
      m_q <= model_pol(m_cfg, din, m_q);
      if (cfg_load) m_cfg <= cfg_word;
    end
  end

  task automatic check_bit(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      logic e;
      e = m_cfg[MODEB] ? m_q : model_pol(m_cfg, din, m_q);
      check_bit("pin_o", pin, e);
      check_bit("fb_o", fb, e);
      check_bit("pin_en_o", pin_en, oe);
    end
  end

  task automatic set_term(int k, logic [L-1:0] tru, logic [L-1:0] cmp);
    for (int j = 0; j < L; j++) begin
      cw[k*TW + 2*j]     = tru[j];
      cw[k*TW + 2*j + 1] = cmp[j];
    end
  endtask

  task automatic kill_all();
    cw = '0;
    for (int k = 0; k < N_PT; k++) set_term(k, 5'b00001, 5'b00001);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load_cfg();
    cfg_word = cw; cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
    cfg_word = {$urandom, $urandom, $urandom};
  endtask

  task automatic sweep(int n);
    for (int i = 0; i < n; i++) begin
      din = N_IN'(i);
      oe  = 1'($urandom);
      step();
    end
  endtask

  initial begin
    rst_n = 1'b0; din = '0; oe = 1'b0; cfg_load = 1'b0; cfg_word = '0; cw = '0;
    step();
    chk_on = 1; tag = "R1";
    step(); step();
    rst_n = 1'b1;
    sweep(4);

    // R2 single term in0 & !in1, others dead
    tag = "R2"; kill_all(); set_term(0, 5'b00001, 5'b00010); load_cfg(); sweep(16);
    // R5 same map inverted
    tag = "R5"; cw[POLB] = 1'b1; load_cfg(); sweep(16);
    // R4 three live terms
    tag = "R4"; kill_all();
    set_term(3, 5'b00011, 5'b00000); set_term(5, 5'b00100, 5'b00000); set_term(7, 5'b00000, 5'b01000);
    load_cfg(); sweep(16);
    // R3 empty term in slot 2, rest dead
    tag = "R3"; kill_all(); set_term(2, 5'b0, 5'b0); load_cfg(); sweep(8);
    kill_all(); set_term(4, 5'b00100, 5'b00100); load_cfg(); sweep(8);
    // R7 combinational XOR-like map
    tag = "R7"; kill_all(); set_term(0, 5'b00001, 5'b00010); set_term(1, 5'b00010, 5'b00001);
    load_cfg(); sweep(16);
    // R6 registered mode
    tag = "R6"; cw[MODEB] = 1'b1; load_cfg();
    for (int i = 0; i < 24; i++) begin din = N_IN'($urandom); oe = 1'($urandom); step(); end
    // R8 feedback toggle in registered and combinational modes
    tag = "R8"; kill_all(); set_term(0, 5'b00000, 5'b10000); cw[MODEB] = 1'b1; load_cfg(); sweep(10);
    cw[MODEB] = 1'b0; load_cfg(); sweep(10);
    // R9 oe noise only
    tag = "R9"; din = 4'b0101;
    for (int i = 0; i < 12; i++) begin oe = ~oe; step(); end
    // R10 word noise without strobe
    tag = "R10"; kill_all(); set_term(6, 5'b01000, 5'b0); load_cfg();
    for (int i = 0; i < 20; i++) begin
      cfg_word = {$urandom, $urandom, $urandom}; din = N_IN'($urandom); step();
    end
    // R1 reset mid-run
    tag = "R1"; cw = '0; cw[MODEB] = 1'b1; set_term(0, 5'b0, 5'b10000); load_cfg(); sweep(3);
    rst_n = 1'b0; step(); step(); rst_n = 1'b1; sweep(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule